// File: doc/BRIEF.md
# Cascadable Four-Channel Timer Unit

The block holds four up-counting timer channels behind a 16-bit register interface. Each channel owns a counter with a reload value and a control word. A channel advances either on ticks from its own prescaler or, in cascade mode, once for every overflow of the channel just below it. When a counter wraps past its all-ones value it takes the reload value, not zero. It then emits a one-cycle overflow pulse, and it raises its interrupt line if its interrupt-enable bit is set.

Software programs a channel by writing its data register, which loads both the live counter and the reload value, and then its control word. Reads return the live count or the stored control word. The overflow pulses of channels 0 and 1 leave the block on dedicated outputs for an audio sample FIFO or a DMA engine. All four channels can overflow in the same clock when they are chained. `rst_n` is asynchronous and active-low, and it is expected to be released synchronously by the clock-domain reset logic.

Top module: `tmr_quad`

## Requirements
- R1: Control word bits: [1:0] prescaler select, [2] cascade, [6] interrupt enable, [7] enable. All 16 written bits are stored and read back unchanged.
- R2: Prescaler select 0 ticks every clock. Selects 1, 2 and 3 tick every 2^DIV_SH1, 2^DIV_SH2 and 2^DIV_SH3 clocks (64, 256 and 1024 by default). With the counter idle and reload R, the first overflow pulse appears exactly (2^CNT_W − R)·divisor clocks after the enabling write edge.
- R3: Each tick adds one to the counter. A tick at the all-ones value loads the reload value and counts as an overflow.
- R4: Writing a channel's data register sets both the live counter and the reload value, and the write wins over a tick in the same cycle. Reading the data register returns the live counter, zero-extended to 16 bits.
- R5: A channel's overflow drives irq_o[n], the bit matching its channel number, high for one cycle after the overflow edge, and only if the interrupt-enable bit is set.
- R6: Overflows of channels 0 and 1 appear as one-cycle pulses on ovf0_o and ovf1_o in the cycle after the overflow edge, whatever the interrupt enable.
- R7: A channel with the cascade bit set ignores its prescaler and advances once per overflow of channel n−1, and only while its own enable bit is set. Channel 0 in cascade mode never advances.
- R8: Cascade propagation is combinational. A chain of channels that all sit at all-ones overflows in a single clock.
- R9: A channel counts from its prescaler only while it is enabled and not in cascade mode. Otherwise its counter holds.
- R10: A channel's prescaler phase restarts from zero on a control write that sets the enable bit from clear, or that changes the prescaler select.
- R11: The byte address map places channel n data at 4n and control at 4n+2. Odd addresses and addresses at or above 4·NUM_CH read zero, and writes to them change nothing.
- R12: Reset clears all counters, reload values, control words, prescaler phases and outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the addressed register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| irq_o | output | NUM_CH | Per-channel interrupt pulses |
| ovf0_o | output | 1 | Channel 0 overflow pulse |
| ovf1_o | output | 1 | Channel 1 overflow pulse |

## Verification
The bench builds the block with an 8-bit counter and prescaler shifts of 2, 3 and 4, giving divisors of 4, 8 and 16. With these values every overflow period is short enough to measure cycle by cycle. Channel 1 is swept over all 256 reload values at full rate, and every prescaler select is timed. The shorter periods also make it practical to test the prescaler phase restart at a known phase and to drive the four-stage chain to a simultaneous overflow.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W    = 16;
  localparam int CTL_SEL0 = 0;
  localparam int CTL_SEL1 = 1;
  localparam int CTL_CASC = 2;
  localparam int CTL_IE   = 6;
  localparam int CTL_EN   = 7;

  typedef struct packed {
    logic       en;
    logic       ie;
    logic       casc;
    logic [1:0] sel;
  } tmr_ctl_t;

  function automatic tmr_ctl_t decode_ctl(input logic [REG_W-1:0] r);
    tmr_ctl_t c;
    c.en   = r[CTL_EN];
    c.ie   = r[CTL_IE];
    c.casc = r[CTL_CASC];
    c.sel  = {r[CTL_SEL1], r[CTL_SEL0]};
    return c;
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int DIV_SH1 = 6,
  parameter int DIV_SH2 = 8,
  parameter int DIV_SH3 = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PRE_W = DIV_SH3;
  localparam logic [PRE_W-1:0] M1 = PRE_W'((1 << DIV_SH1) - 1);
  localparam logic [PRE_W-1:0] M2 = PRE_W'((1 << DIV_SH2) - 1);
  localparam logic [PRE_W-1:0] M3 = PRE_W'((1 << DIV_SH3) - 1);

  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (clr)      pre_d = '0;
    else if (run) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  always_comb begin
    unique case (sel)
      2'd0:    tick = run;
      2'd1:    tick = run && ((pre_q & M1) == M1);
      2'd2:    tick = run && ((pre_q & M2) == M2);
      default: tick = run && ((pre_q & M3) == M3);
    endcase
  end

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wval,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, rel_d;

  assign ovf_o = inc && !wr && (cnt_q == '1);
  assign cnt_o = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    rel_d = rel_q;
    if (wr) begin
      cnt_d = wval;
      rel_d = wval;
    end else if (inc) begin
      cnt_d = (cnt_q == '1) ? rel_q : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
    end
  end

  assert_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == rel_q));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr) |=> $stable(cnt_q));
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == $past(wval)));
endmodule

// File: rtl/tmr_quad.sv
module tmr_quad
  import tmr_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  parameter int ADDR_W  = 5,
  parameter int DIV_SH1 = 6,
  parameter int DIV_SH2 = 8,
  parameter int DIV_SH3 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [NUM_CH-1:0] irq_o,
  output logic              ovf0_o,
  output logic              ovf1_o
);
  localparam int CH_W = ADDR_W - 2;

  logic [CH_W-1:0]   sel_ch;
  logic              hit, is_ctl;
  logic [REG_W-1:0]  ctl_q [NUM_CH];
  logic [REG_W-1:0]  ctl_d [NUM_CH];
  logic [CNT_W-1:0]  cnt   [NUM_CH];
  logic [NUM_CH-1:0] ctl_wr, dat_wr, clr, run, tick, inc, ovf, casc_in, ie_vec;
  logic [NUM_CH-1:0] ovf_q, irq_q;

  assign sel_ch  = addr[ADDR_W-1:2];
  assign is_ctl  = addr[1];
  assign hit     = !addr[0] && (32'(sel_ch) < NUM_CH);
  assign casc_in = {ovf[NUM_CH-2:0], 1'b0};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_ctl_t c;
    assign c         = decode_ctl(ctl_q[g]);
    assign ctl_wr[g] = wr_en && hit && is_ctl  && (sel_ch == CH_W'(g));
    assign dat_wr[g] = wr_en && hit && !is_ctl && (sel_ch == CH_W'(g));
    assign clr[g]    = ctl_wr[g] && ((wdata[CTL_EN] && !c.en) ||
                       (wdata[CTL_SEL1:CTL_SEL0] != c.sel));
    assign run[g]    = c.en && !c.casc;
    assign inc[g]    = c.en && (c.casc ? casc_in[g] : tick[g]);
    assign ie_vec[g] = c.ie;

    always_comb ctl_d[g] = ctl_wr[g] ? wdata : ctl_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[g] <= '0;
      else        ctl_q[g] <= ctl_d[g];
    end

    tmr_prescale #(.DIV_SH1(DIV_SH1), .DIV_SH2(DIV_SH2), .DIV_SH3(DIV_SH3)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run[g]), .clr(clr[g]), .sel(c.sel), .tick(tick[g]));

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr(dat_wr[g]), .wval(wdata[CNT_W-1:0]),
      .inc(inc[g]), .cnt_o(cnt[g]), .ovf_o(ovf[g]));

    assert_irq_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[g] |-> ($past(ovf[g]) && $past(ctl_q[g][CTL_IE])));

    if (g > 0) begin : g_chain
      assert_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf[g-1] && ctl_q[g][CTL_CASC] && ctl_q[g][CTL_EN] && !dat_wr[g] &&
         (cnt[g] == '1)) |-> ovf[g]);
    end
  end

  always_comb begin
    rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (hit && (sel_ch == CH_W'(n)))
        rdata = is_ctl ? ctl_q[n] : REG_W'(cnt[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= '0;
      irq_q <= '0;
    end else begin
      ovf_q <= ovf;
      irq_q <= ovf & ie_vec;
    end
  end

  assign irq_o  = irq_q;
  assign ovf0_o = ovf_q[0];
  assign ovf1_o = ovf_q[1];

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf0_o |-> $past(ovf[0]));
endmodule

// File: tb/sim_tmr_quad.sv
module sim_tmr_quad;
  localparam int NUM_CH = 4, CNT_W = 8, ADDR_W = 5;
  localparam int SH1 = 2, SH2 = 3, SH3 = 4;
  localparam int TOP = 1 << CNT_W;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic [NUM_CH-1:0] irq_o;
  logic ovf0_o, ovf1_o;
  int nchk = 0, nfail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_quad #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W),
             .DIV_SH1(SH1), .DIV_SH2(SH2), .DIV_SH3(SH3)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o), .ovf0_o(ovf0_o), .ovf1_o(ovf1_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    addr = ADDR_W'(a);
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic measure(input bit ch1, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(ch1 ? ovf1_o : ovf0_o) && n < 5000);
  endtask

  initial begin
    #(4 * 190000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n, dv;
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    for (int a = 0; a < 16; a += 2) begin
      rd(a, v); chk("R12 reg after reset", v, 0);
    end
    chk("R12 outputs after reset", {irq_o, ovf0_o, ovf1_o}, 0);

    // R1: all control bits stored
    wr(14, 16'hA53B); rd(14, v); chk("R1 ctl readback", v, 16'hA53B);
    wr(14, 16'h5AC4); rd(14, v); chk("R1 ctl readback", v, 16'h5AC4);
    wr(14, 16'h0000);

    // R11: unmapped addresses
    wr(16, 16'hFFFF); wr(30, 16'hFFFF); wr(1, 16'hFFFF); wr(3, 16'hFFFF);
    for (int a = 0; a < 16; a += 2) begin
      rd(a, v); chk("R11 mapped reg untouched", v, 0);
    end
    rd(1, v);  chk("R11 odd addr reads zero", v, 0);
    rd(16, v); chk("R11 high addr reads zero", v, 0);
    rd(30, v); chk("R11 high addr reads zero", v, 0);

    // R2 R3 R6: prescaler selects on channel 0, reload TOP-3
    for (int s = 0; s < 4; s++) begin
      dv = (s == 0) ? 1 : (1 << ((s == 1) ? SH1 : (s == 2) ? SH2 : SH3));
      wr(2, 16'h0000);
      wr(0, 16'(TOP - 3));
      wr(2, 16'(16'h0080 | s));
      measure(1'b0, n); chk("R2 first overflow period", n, 3 * dv);
      rd(0, v); chk("R3 reload after wrap", v, TOP - 3);
      @(negedge clk); chk("R6 ovf0 one-cycle pulse", ovf0_o, 0);
      measure(1'b0, n); chk("R2 second overflow period", n, 3 * dv - 1);
    end
    wr(2, 16'h0000);

    // R2 exhaustive reload sweep on channel 1, select 0
    for (int r = 0; r < TOP; r++) begin
      wr(6, 16'h0000);
      wr(4, 16'(r));
      wr(6, 16'h0080);
      measure(1'b1, n); chk("R2 R6 ch1 reload sweep", n, TOP - r);
    end
    wr(6, 16'h0000);

    // R4: data write and live readback
    wr(8, 16'h0040); rd(8, v); chk("R4 data write", v, 16'h40);
    wr(10, 16'h0080); rd(8, v); chk("R4 no tick on enable edge", v, 16'h40);
    wait_cyc(5); rd(8, v); chk("R4 live count", v, 16'h45);
    wr(8, 16'h0010); rd(8, v); chk("R4 write wins over tick", v, 16'h10);
    @(negedge clk); rd(8, v); chk("R4 counts from written value", v, 16'h11);

    // R9: disabled and cascade-without-source hold
    wr(10, 16'h0000); rd(8, v);
    wait_cyc(10); rd(8, n); chk("R9 disabled holds", n, v);
    wr(10, 16'h0084);
    wait_cyc(10); rd(8, n); chk("R9 cascade ignores prescaler", n, v);
    wr(10, 16'h0000);

    // R7: channel 0 in cascade never counts
    wr(0, 16'h00FE); wr(2, 16'h0084);
    wait_cyc(20); rd(0, v); chk("R7 ch0 cascade idle", v, 16'hFE);
    wr(2, 16'h0000);

    // R7: cascade needs own enable
    wr(4, 16'h0033); wr(6, 16'h0004);
    wr(0, 16'h00FE); wr(2, 16'h0080);
    wait_cyc(10); rd(4, v); chk("R7 cascade without enable holds", v, 16'h33);
    wr(2, 16'h0000);

    // R7: cascade counts lower overflows
    wr(4, 16'h0010); wr(6, 16'h0084);
    wr(0, 16'h00FC); wr(2, 16'h0080);
    wait_cyc(20); rd(4, v); chk("R7 cascade count", v, 16'h15);
    wr(2, 16'h0000); wr(6, 16'h0000);

    // R5: interrupt gating
    wr(0, 16'h00FE); wr(2, 16'h00C0);
    @(negedge clk); chk("R5 no irq before overflow", irq_o, 0);
    @(negedge clk); chk("R5 irq on overflow", irq_o, 4'b0001);
    chk("R6 ovf0 with irq", ovf0_o, 1);
    wr(2, 16'h0080);
    n = 0; v = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (ovf0_o) n++;
      v = v | 16'(irq_o);
    end
    chk("R5 irq masked", v, 0);
    chk("R6 ovf0 pulses without irq enable", n, 2);
    wr(2, 16'h0000);

    // R8: four-stage same-cycle chain
    for (int c = 0; c < 4; c++) wr(4 * c, 16'h00FF);
    for (int c = 1; c < 4; c++) wr(4 * c + 2, 16'h00C4);
    wr(2, 16'h00C0);
    @(negedge clk);
    chk("R8 all channels overflow together", irq_o, 4'b1111);
    chk("R6 ovf0 and ovf1 in chain", {ovf0_o, ovf1_o}, 2'b11);
    for (int c = 0; c < 4; c++) wr(4 * c + 2, 16'h0000);

    // R10: select change restarts prescaler phase
    wr(8, 16'h0000); wr(10, 16'h0082);
    wait_cyc(4);
    wr(10, 16'h0081);
    wait_cyc(3); rd(8, v); chk("R10 no tick before new period", v, 0);
    @(negedge clk); rd(8, v); chk("R10 tick at new period", v, 1);
    wait_cyc(1);
    wr(10, 16'h0000); wr(8, 16'h0000); wr(10, 16'h0081);
    wait_cyc(3); rd(8, v); chk("R10 enable restart no early tick", v, 0);
    @(negedge clk); rd(8, v); chk("R10 enable restart tick", v, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule